// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device

This block is the device end of a three-wire serial EEPROM link. A host raises chip select, clocks a start bit, a two-bit opcode, an address and optional data into the serial input on rising serial-clock edges, and the block runs the command against an internal byte array. The array can be seen as bytes or as 16-bit words. A strap input picks the view, and the address width follows from it.

All pins are sampled into one system clock domain. Serial-clock edges and chip-select falls are found from the sampled values. Reads stream data out MSB first and can run on through the array indefinitely. Any command that changes the array is held back until chip select falls inside a narrow window. It then starts a programming cycle, which a counter times. Programming is blocked until the host enables it with a command. While a programming cycle runs, and after it ends, raising chip select shows busy or ready on the data output. The output is modelled as a value plus an output-enable, in place of a tri-state pin. The power-on reset is the reset input.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset the array holds all ones: 8'hFF per byte, 16'hFFFF per word. Programming is disabled and do_oe_o is low.
- R2: A command begins at the first 1 sampled on di_i at a rising sk_i edge while cs_i is high. Leading zeros are skipped. The next two bits are the opcode: 2'b10 read, 2'b01 write, 2'b11 erase, 2'b00 extended. For an extended command, the two most significant address bits pick the action: 2'b11 enable programming, 2'b00 disable programming, 2'b10 erase all, 2'b01 write all.
- R3: The address is 9 bits with org16_i low (byte view) and 8 bits with org16_i high (word view). It is sent MSB first. Data is 8 or 16 bits, MSB first. Word n is bytes 2n (high half) and 2n+1 (low half).
- R4: A read drives a 0 dummy bit from the rising edge that samples the last address bit. Each later rising edge then presents the next data bit, MSB first.
- R5: While cs_i stays high, a read continues with the next location and no dummy bit. After the top location it wraps to location 0.
- R6: While programming is disabled, write, erase, erase-all and write-all leave the array unchanged. Reads always work.
- R7: Erase sets one location to all ones. Erase-all sets every byte to 8'hFF. Write-all stores the data value in every location. A write replaces the old value with no prior erase.
- R8: A change commits only when cs_i falls after the last bit has been sampled and before any further rising sk_i edge. Falling earlier, or after an extra edge, leaves the array unchanged.
- R9: A committed change keeps the block busy for PROG_CYCLES system clocks. During that time, with cs_i high, do_o shows 0; after it ends, do_o shows 1. Serial input is ignored while busy. The ready indication is dropped by the next chip-select fall once the block is ready, or by a new start bit.
- R10: do_oe_o is low whenever the sampled chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-on) |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| org16_i | input | 1 | Organisation strap: 1 word view, 0 byte view |
| do_o | output | 1 | Serial data / ready-busy out |
| do_oe_o | output | 1 | Output enable for do_o |

## Verification
The bench sweeps the whole array with streaming reads after reset, after erase-all and after write-all in both views. A wrong byte-pair mapping or a missed wrap at the top address shows up as wrong words at the edges. It cuts write frames short, and also adds one extra clock after the last bit. A design that commits anyway corrupts the byte the bench later reads back. It also checks the following:
- Commands are ignored while programming is disabled.
- A command is sent in the middle of a busy period.
- Leading zeros come before the start bit.
- The ready level appears on do_o and is later dropped.

A design that misses any of these either changes data it must not change, or drives the output when it should not.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_ARMED, ST_SKIP
  } mw_state_e;

  typedef enum logic [1:0] {
    PG_WRITE, PG_ERASE, PG_ERAL, PG_WRAL
  } mw_prog_e;
endpackage

// File: rtl/mw_pin_sampler.sv
module mw_pin_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic cs_o,
  output logic di_o,
  output logic sk_rise_o,
  output logic cs_fall_o
);
  logic [2:0] s1_q, s2_q;
  logic       cs_d_q, sk_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      cs_d_q <= 1'b0;
      sk_d_q <= 1'b0;
    end else begin
      s1_q   <= {cs_i, sk_i, di_i};
      s2_q   <= s1_q;
      cs_d_q <= s2_q[2];
      sk_d_q <= s2_q[1];
    end
  end

  assign cs_o      = s2_q[2];
  assign di_o      = s2_q[0];
  assign sk_rise_o = s2_q[1] & ~sk_d_q;
  assign cs_fall_o = cs_d_q & ~s2_q[2];
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int unsigned CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)      cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/mw_byte_array.sv
module mw_byte_array
  import mw_pkg::*;
#(
  parameter int unsigned AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  mw_prog_e      op_i,
  input  logic          org16_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [15:0]   wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [15:0]   rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [7:0] mem_q [DEPTH];

  function automatic logic [7:0] next_byte(input int unsigned i, input logic [7:0] cur);
    logic [AW-1:0] idx;
    logic          hit;
    logic [7:0]    half;
    idx  = AW'(i);
    hit  = org16_i ? (waddr_i[AW-2:0] == idx[AW-1:1]) : (waddr_i == idx);
    half = (org16_i && !idx[0]) ? wdata_i[15:8] : wdata_i[7:0];
    case (op_i)
      PG_WRITE: next_byte = hit ? half : cur;
      PG_ERASE: next_byte = hit ? 8'hFF : cur;
      PG_ERAL:  next_byte = 8'hFF;
      default:  next_byte = half;
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= next_byte(i, mem_q[i]);
    end
  end

  // byte view: data left-aligned so the shifter always leaves from bit 15
  assign rdata_o = org16_i ? {mem_q[{raddr_i[AW-2:0], 1'b0}], mem_q[{raddr_i[AW-2:0], 1'b1}]}
                           : {mem_q[raddr_i], 8'h00};
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mw_pkg::*;
#(
  parameter int unsigned ADDR8_W     = 9,
  parameter int unsigned PROG_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  input  logic org16_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int unsigned ADDR16_W = ADDR8_W - 1;
  localparam int unsigned CNT_W    = $clog2(ADDR8_W + 17);

  logic cs_s, di_s, sk_rise, cs_fall, busy, prog_start, rd_act;
  mw_state_e state_q;
  mw_prog_e  pend_q;
  logic [1:0]         op_q, ext_sel;
  logic [ADDR8_W-1:0] addr_q, rd_addr_q, addr_shift, rd_inc, rd_ptr, addr_mask;
  logic [15:0]        data_q, rd_sh_q, rd_word;
  logic [CNT_W-1:0]   cnt_q, rd_left_q, aw, dw;
  logic               org_q, wr_en_q, stat_en_q, dout_q;

  mw_pin_sampler u_pins (
    .clk_i, .rst_ni, .cs_i, .sk_i, .di_i,
    .cs_o(cs_s), .di_o(di_s), .sk_rise_o(sk_rise), .cs_fall_o(cs_fall)
  );

  mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(prog_start), .busy_o(busy)
  );

  mw_byte_array #(.AW(ADDR8_W)) u_array (
    .clk_i, .rst_ni, .we_i(prog_start), .op_i(pend_q), .org16_i(org_q),
    .waddr_i(addr_q), .wdata_i(data_q), .raddr_i(rd_ptr), .rdata_o(rd_word)
  );

  assign aw         = org_q ? CNT_W'(ADDR16_W) : CNT_W'(ADDR8_W);
  assign dw         = org_q ? CNT_W'(16) : CNT_W'(8);
  assign addr_mask  = org_q ? {1'b0, {ADDR16_W{1'b1}}} : {ADDR8_W{1'b1}};
  assign addr_shift = {addr_q[ADDR8_W-2:0], di_s};
  assign ext_sel    = org_q ? addr_shift[ADDR8_W-2 -: 2] : addr_shift[ADDR8_W-1 -: 2];
  assign rd_inc     = (rd_addr_q + ADDR8_W'(1)) & addr_mask;
  assign rd_ptr     = (state_q == ST_ADDR) ? addr_shift : rd_inc;
  assign prog_start = cs_fall && (state_q == ST_ARMED);
  assign rd_act     = (state_q == ST_READ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pend_q    <= PG_WRITE;
      op_q      <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      cnt_q     <= '0;
      rd_addr_q <= '0;
      rd_sh_q   <= '0;
      rd_left_q <= '0;
      org_q     <= 1'b0;
      wr_en_q   <= 1'b0;
      stat_en_q <= 1'b0;
      dout_q    <= 1'b0;
    end else if (cs_fall) begin
      state_q <= ST_IDLE;
      if (prog_start)  stat_en_q <= 1'b1;
      else if (!busy)  stat_en_q <= 1'b0;
    end else if (sk_rise && cs_s && !busy) begin
      unique case (state_q)
        ST_IDLE: if (di_s) begin
          state_q   <= ST_OPC;
          cnt_q     <= '0;
          org_q     <= org16_i;
          addr_q    <= '0;
          data_q    <= '0;
          stat_en_q <= 1'b0;
        end
        ST_OPC: begin
          op_q <= {op_q[0], di_s};
          if (cnt_q == CNT_W'(1)) begin
            state_q <= ST_ADDR;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_ADDR: begin
          addr_q <= addr_shift;
          if (cnt_q == aw - CNT_W'(1)) begin
            cnt_q <= '0;
            unique case (op_q)
              2'b10: begin
                state_q   <= ST_READ;
                rd_addr_q <= addr_shift;
                rd_sh_q   <= rd_word;
                rd_left_q <= dw;
                dout_q    <= 1'b0;
              end
              2'b01: begin
                pend_q  <= PG_WRITE;
                state_q <= ST_DATA;
              end
              2'b11: begin
                pend_q  <= PG_ERASE;
                state_q <= wr_en_q ? ST_ARMED : ST_SKIP;
              end
              default: unique case (ext_sel)
                2'b11: begin wr_en_q <= 1'b1; state_q <= ST_SKIP; end
                2'b00: begin wr_en_q <= 1'b0; state_q <= ST_SKIP; end
                2'b10: begin
                  pend_q  <= PG_ERAL;
                  state_q <= wr_en_q ? ST_ARMED : ST_SKIP;
                end
                default: begin
                  pend_q  <= PG_WRAL;
                  state_q <= ST_DATA;
                end
              endcase
            endcase
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_DATA: begin
          data_q <= {data_q[14:0], di_s};
          if (cnt_q == dw - CNT_W'(1)) state_q <= wr_en_q ? ST_ARMED : ST_SKIP;
          else                         cnt_q   <= cnt_q + CNT_W'(1);
        end
        ST_READ: begin
          if (rd_left_q == '0) begin
            dout_q    <= rd_word[15];
            rd_sh_q   <= {rd_word[14:0], 1'b0};
            rd_addr_q <= rd_inc;
            rd_left_q <= dw - CNT_W'(1);
          end else begin
            dout_q    <= rd_sh_q[15];
            rd_sh_q   <= {rd_sh_q[14:0], 1'b0};
            rd_left_q <= rd_left_q - CNT_W'(1);
          end
        end
        ST_ARMED: state_q <= ST_SKIP;  // extra edge past the frame: no commit
        default:  state_q <= ST_SKIP;
      endcase
    end
  end

  assign do_oe_o = cs_s & (rd_act | stat_en_q);
  assign do_o    = rd_act ? dout_q : ~busy;
endmodule

// File: rtl/mw_eeprom_slave_chk.sv
module mw_eeprom_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic do_o,
  input logic do_oe_o,
  input logic cs_s,
  input logic busy,
  input logic prog_start,
  input logic wr_en_q,
  input logic rd_act
);
  a_r9_busy_shows_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && do_oe_o) |-> !do_o);
  a_r10_released_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |-> !do_oe_o);
  a_r6_commit_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start |-> wr_en_q);
  a_r9_no_restart_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start |-> !busy);
  a_r8_commit_starts_timer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start |=> busy);
  a_r4_read_drives_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act && cs_s) |-> do_oe_o);
  a_r9_read_blocked_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !rd_act);
endmodule

bind mw_eeprom_slave mw_eeprom_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .do_o(do_o), .do_oe_o(do_oe_o), .cs_s(cs_s),
  .busy(busy), .prog_start(prog_start), .wr_en_q(wr_en_q), .rd_act(rd_act)
);

// File: tb/mw_eeprom_slave_test.sv
module mw_eeprom_slave_test;
  localparam int PROG = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b0;
  logic do_w, oe_w;
  int n_chk = 0, n_fail = 0;
  logic [7:0] m [512];

  always #10 clk = ~clk;

  mw_eeprom_slave #(.ADDR8_W(9), .PROG_CYCLES(PROG)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .org16_i(org), .do_o(do_w), .do_oe_o(oe_w)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    di = b;
    wait_n(3);
    sk = 1'b1;
    wait_n(3);
    sk = 1'b0;
  endtask

  task automatic send(input int val, input int n);
    for (int i = n - 1; i >= 0; i--) pulse(val[i]);
  endtask

  task automatic cs_hi(input logic o);
    org = o;
    cs  = 1'b1;
    wait_n(3);
  endtask

  task automatic cs_lo();
    cs = 1'b0;
    wait_n(4);
  endtask

  function automatic int awid(input logic o); return o ? 8 : 9; endfunction
  function automatic int dwid(input logic o); return o ? 16 : 8; endfunction
  function automatic int ext_addr(input int code, input logic o);
    return code << (awid(o) - 2);
  endfunction

  // start bit, opcode, address, the first nd data bits, then extra clocks
  task automatic frame(input int op, input int addr, input logic o, input int data,
                       input int nd, input int extra);
    cs_hi(o);
    pulse(1'b1);
    send(op, 2);
    send(addr, awid(o));
    for (int i = dwid(o) - 1; i >= dwid(o) - nd; i--) pulse(data[i]);
    repeat (extra) pulse(1'b0);
  endtask

  // model: 0 write, 1 erase, 2 erase-all, 3 write-all
  task automatic m_prog(input int kind, input int a, input logic o, input int d);
    for (int i = 0; i < 512; i++) begin
      logic hit;
      logic [7:0] half;
      hit  = o ? ((i / 2) == a) : (i == a);
      half = (o && (i % 2 == 0)) ? d[15:8] : d[7:0];
      case (kind)
        0: if (hit) m[i] = half;
        1: if (hit) m[i] = 8'hFF;
        2: m[i] = 8'hFF;
        default: m[i] = half;
      endcase
    end
  endtask

  function automatic int exp_word(input int n, input logic o);
    return o ? {m[2*n], m[2*n+1]} : int'(m[n]);
  endfunction

  task automatic rd_stream(input int start, input logic o, input int count, input string req);
    int words;
    words = o ? 256 : 512;
    frame(2, start, o, 0, 0, 0);
    chk(oe_w === 1'b1 && do_w === 1'b0, "R4 dummy bit", {oe_w, do_w}, 2);
    for (int k = 0; k < count; k++) begin
      int got, e;
      got = 0;
      for (int b = 0; b < dwid(o); b++) begin
        pulse(1'b0);
        got = (got << 1) | int'(do_w);
      end
      e = exp_word((start + k) % words, o);
      chk(got == e, req, got, e);
    end
    cs_lo();
  endtask

  task automatic ext_cmd(input int code, input logic o);
    frame(0, ext_addr(code, o), o, 0, 0, 0);
    cs_lo();
  endtask

  initial begin
    for (int i = 0; i < 512; i++) m[i] = 8'hFF;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    chk(oe_w === 1'b0, "R1 output released after reset", oe_w, 0);
    chk(oe_w === 1'b0, "R10 released with cs low", oe_w, 0);

    // R1 R3 R4: full word-view sweep of the reset contents
    rd_stream(0, 1'b1, 256, "R1 reset word");

    // R6: write while disabled
    frame(1, 5, 1'b0, 8'h12, 8, 0);
    cs_lo();
    wait_n(PROG + 60);
    rd_stream(5, 1'b0, 1, "R6 write ignored when disabled");

    // R2: enable then write, with status on do_o
    ext_cmd(3, 1'b0);
    frame(1, 5, 1'b0, 8'h12, 8, 0);
    cs_lo();
    m_prog(0, 5, 1'b0, 8'h12);
    cs = 1'b1;
    wait_n(4);
    chk(oe_w === 1'b1 && do_w === 1'b0, "R9 busy", {oe_w, do_w}, 2);
    wait_n(PROG + 20);
    chk(oe_w === 1'b1 && do_w === 1'b1, "R9 ready", {oe_w, do_w}, 3);
    cs_lo();
    chk(oe_w === 1'b0, "R10 released after status", oe_w, 0);
    cs = 1'b1;
    wait_n(4);
    chk(oe_w === 1'b0, "R9 ready dropped after deselect", oe_w, 0);
    cs_lo();
    rd_stream(5, 1'b0, 1, "R2 enable then write");

    // R3: word write lands on byte pair, high half first
    frame(1, 3, 1'b1, 16'hA55A, 16, 0);
    cs_lo();
    m_prog(0, 3, 1'b1, 16'hA55A);
    wait_n(PROG + 60);
    rd_stream(6, 1'b0, 2, "R3 word to byte pair");

    // R7: overwrite without erase
    frame(1, 5, 1'b0, 8'h34, 8, 0);
    cs_lo();
    m_prog(0, 5, 1'b0, 8'h34);
    wait_n(PROG + 60);
    rd_stream(5, 1'b0, 1, "R7 overwrite");

    // R8: early deselect, then one extra clock
    frame(1, 5, 1'b0, 8'hFF, 7, 0);
    cs_lo();
    wait_n(PROG + 60);
    rd_stream(5, 1'b0, 1, "R8 short frame no commit");
    frame(1, 5, 1'b0, 8'h00, 8, 1);
    cs_lo();
    wait_n(PROG + 60);
    rd_stream(5, 1'b0, 1, "R8 extra clock no commit");

    // R2: leading zeros before the start bit
    cs_hi(1'b0);
    send(0, 3);
    pulse(1'b1);
    send(2, 2);
    send(5, 9);
    for (int b = 0; b < 9; b++) begin
      int got;
      got = 0;
      if (b > 0) pulse(1'b0);
      got = int'(do_w);
      if (b == 0) chk(do_w === 1'b0, "R2 dummy after zeros", got, 0);
    end
    begin
      int got;
      got = 0;
      frame(2, 5, 1'b0, 0, 0, 0);
      cs_lo();
      cs_hi(1'b0);
      send(0, 2);
      pulse(1'b1);
      send(2, 2);
      send(5, 9);
      for (int b = 0; b < 8; b++) begin
        pulse(1'b0);
        got = (got << 1) | int'(do_w);
      end
      chk(got == 8'h34, "R2 leading zeros skipped", got, 8'h34);
      cs_lo();
    end

    // R9: command sent while busy is ignored
    frame(1, 20, 1'b0, 8'h5A, 8, 0);
    cs_lo();
    m_prog(0, 20, 1'b0, 8'h5A);
    frame(3, 20, 1'b0, 0, 0, 0);
    cs_lo();
    wait_n(PROG + 60);
    rd_stream(20, 1'b0, 1, "R9 input ignored while busy");

    // R7: erase one word
    frame(3, 3, 1'b1, 0, 0, 0);
    cs_lo();
    m_prog(1, 3, 1'b1, 0);
    wait_n(PROG + 60);
    rd_stream(3, 1'b1, 1, "R7 erase word");

    // R5: wrap across the top in both views
    frame(1, 511, 1'b0, 8'h77, 8, 0);
    cs_lo();
    m_prog(0, 511, 1'b0, 8'h77);
    wait_n(PROG + 60);
    frame(1, 0, 1'b0, 8'h66, 8, 0);
    cs_lo();
    m_prog(0, 0, 1'b0, 8'h66);
    wait_n(PROG + 60);
    rd_stream(510, 1'b0, 4, "R5 byte wrap");
    rd_stream(255, 1'b1, 2, "R5 word wrap");

    // R6: disable, erase-all ignored, read still works
    ext_cmd(0, 1'b1);
    ext_cmd(2, 1'b1);
    wait_n(PROG + 60);
    rd_stream(5, 1'b0, 1, "R6 erase-all ignored");
    frame(0, ext_addr(1, 1'b0), 1'b0, 8'h00, 8, 0);
    cs_lo();
    wait_n(PROG + 60);
    rd_stream(20, 1'b0, 1, "R6 write-all ignored");

    // R7: erase-all then byte sweep
    ext_cmd(3, 1'b1);
    ext_cmd(2, 1'b1);
    m_prog(2, 0, 1'b1, 0);
    wait_n(PROG + 60);
    rd_stream(0, 1'b0, 512, "R7 erase-all");

    // R7 R3: word write-all, byte sweep
    frame(0, ext_addr(1, 1'b1), 1'b1, 16'h5AC3, 16, 0);
    cs_lo();
    m_prog(3, 0, 1'b1, 16'h5AC3);
    wait_n(PROG + 60);
    rd_stream(0, 1'b0, 512, "R7 write-all word");

    // R7: byte write-all, read as words
    frame(0, ext_addr(1, 1'b0), 1'b0, 8'h81, 8, 0);
    cs_lo();
    m_prog(3, 0, 1'b0, 8'h81);
    wait_n(PROG + 60);
    rd_stream(0, 1'b1, 4, "R7 write-all byte");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule